// File: doc/BRIEF.md
# Predicated Integer ALU Stage

This block is the execute stage of a 32-bit integer pipeline. Each cycle it may accept one data-processing operation. The operation arrives as operand A, operand B that an upstream shifter has already formed, the carry bit that shifter produced, a 4-bit opcode, a 4-bit condition code, a set-flags bit and the current NZCV flags.

The stage first tests the condition code against the incoming flags. When the test passes, it computes the result and decides whether a destination register write takes place. It also decides whether the flags are replaced by the newly computed ones or passed through unchanged. When the test fails, the operation has no effect.

The result, write enable and next flags are registered, so they appear one clock after the operation is presented. The surrounding pipeline writes `nxt_flags` back into its flag register on every cycle in which `res_valid` is high.

Top module: `pred_alu_stage`

## Requirements
- R1: Opcodes 0100 ADD, 0101 ADC, 0010 SUB, 0110 SBC, 0011 RSB and 0111 RSC give A+B, A+B+C, A-B, A-B-1+C, B-A and B-A-1+C modulo 2^32, where C is the incoming carry flag.
- R2: Opcodes 0000 AND, 0001 EOR, 1100 ORR and 1110 BIC give A&B, A^B, A|B and A&~B. Opcodes 1101 MOV and 1111 MVN give B and ~B, and the value of A has no effect on their result.
- R3: Opcodes 1000 TST (A&B), 1001 TEQ (A^B), 1010 CMP (A-B) and 1011 CMN (A+B) never raise the write enable. When their condition passes they replace the flags whatever the set-flags bit is.
- R4: A non-compare operation with the set-flags bit low returns the incoming flags unchanged on `nxt_flags`.
- R5: Condition codes, encoded 0 to 14 in this order: EQ Z; NE !Z; CS C; CC !C; MI N; PL !N; VS V; VC !V; HI C&!Z; LS !C|Z; GE N==V; LT N!=V; GT !Z&(N==V); LE Z|(N!=V); AL always.
- R6: When the condition fails, including code 1111, which never passes, the write enable is low and `nxt_flags` equals the incoming flags.
- R7: For the arithmetic and compare-arithmetic opcodes, C is the carry out of bit 31 (1 means no borrow on a subtraction) and V is signed two's-complement overflow.
- R8: For the logical, move and test opcodes, C takes the shifter carry input and V keeps its incoming value.
- R9: Whenever flags are replaced, N is bit 31 of the result and Z is 1 exactly when the 32-bit result is zero. Flag bus bit order is {N,Z,C,V}, from bit 3 down to bit 0.
- R10: Outputs are registered one cycle after `op_valid`, and `res_valid` follows `op_valid` with that delay. Outputs hold their values while `op_valid` is low. During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_a | input | 32 | Operand A from the register file |
| op_b | input | 32 | Shifted operand B |
| shift_carry | input | 1 | Carry out of the operand B shifter |
| opcode | input | 4 | Operation select |
| cond | input | 4 | Condition code |
| set_flags | input | 1 | Request flag update for non-compare operations |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_valid | output | 1 | Registered copy of op_valid |
| res_we | output | 1 | Destination write enable |
| res_data | output | 32 | Operation result |
| nxt_flags | output | 4 | Flags after the operation {N,Z,C,V} |

## Verification
A table of hand-derived vectors sits at the carry and overflow edges: all-ones plus one, the largest positive value plus one, equal operands, and subtraction with borrow-in both set and clear. These separate carry from overflow, and carry from not-borrow. All 16 condition codes are swept against all 16 flag combinations, which separates each predicate from its neighbours and shows that code 1111 never passes. Random operands, opcodes, conditions and set-flags values are then compared against an independent model written with wide signed arithmetic. Directed steps cover reset values, output hold while idle, and a MOV whose result must not depend on operand A.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_compare(alu_op_e op);
    return (op[3:2] == 2'b10);
  endfunction

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_alu_pkg::*;
(
  input  cond_e cond,
  input  nzcv_t flg,
  output logic  pass
);

  always_comb begin
    unique case (cond)
      CC_EQ: pass = flg.z;
      CC_NE: pass = !flg.z;
      CC_CS: pass = flg.c;
      CC_CC: pass = !flg.c;
      CC_MI: pass = flg.n;
      CC_PL: pass = !flg.n;
      CC_VS: pass = flg.v;
      CC_VC: pass = !flg.v;
      CC_HI: pass = flg.c && !flg.z;
      CC_LS: pass = !flg.c || flg.z;
      CC_GE: pass = (flg.n == flg.v);
      CC_LT: pass = (flg.n != flg.v);
      CC_GT: pass = !flg.z && (flg.n == flg.v);
      CC_LE: pass = flg.z || (flg.n != flg.v);
      CC_AL: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/pred_alu_adder.sv
module pred_alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
  end

endmodule

// File: rtl/pred_alu_datapath.sv
module pred_alu_datapath
  import pred_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         shc,
  input  alu_op_e      op,
  input  nzcv_t        flg_in,
  output logic [W-1:0] result,
  output nzcv_t        flg_calc,
  output logic         is_cmp
);

  logic [W-1:0] add_x, add_y, add_sum;
  logic         add_cin, add_cout, add_ovf;
  logic         is_arith;

  always_comb begin
    add_x   = a;
    add_y   = b;
    add_cin = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin add_x = a; add_y = b;  add_cin = 1'b0;     end
      OP_ADC:         begin add_x = a; add_y = b;  add_cin = flg_in.c; end
      OP_SUB, OP_CMP: begin add_x = a; add_y = ~b; add_cin = 1'b1;     end
      OP_SBC:         begin add_x = a; add_y = ~b; add_cin = flg_in.c; end
      OP_RSB:         begin add_x = b; add_y = ~a; add_cin = 1'b1;     end
      OP_RSC:         begin add_x = b; add_y = ~a; add_cin = flg_in.c; end
      default:        begin add_x = a; add_y = b;  add_cin = 1'b0;     end
    endcase
  end

  pred_alu_adder #(.W(W)) u_adder (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  always_comb begin
    is_arith = 1'b0;
    unique case (op)
      OP_AND, OP_TST: result = a & b;
      OP_EOR, OP_TEQ: result = a ^ b;
      OP_ORR:         result = a | b;
      OP_BIC:         result = a & ~b;
      OP_MOV:         result = b;
      OP_MVN:         result = ~b;
      default: begin
        result   = add_sum;
        is_arith = 1'b1;
      end
    endcase
    is_cmp     = op_is_compare(op);
    flg_calc.n = result[W-1];
    flg_calc.z = (result == '0);
    flg_calc.c = is_arith ? add_cout : shc;
    flg_calc.v = is_arith ? add_ovf : flg_in.v;
  end

endmodule

// File: rtl/pred_alu_stage.sv
module pred_alu_stage
  import pred_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              shift_carry,
  input  logic [3:0]        opcode,
  input  logic [3:0]        cond,
  input  logic              set_flags,
  input  logic [3:0]        flags_in,
  output logic              res_valid,
  output logic              res_we,
  output logic [DATA_W-1:0] res_data,
  output logic [3:0]        nxt_flags
);

  // reset: asserted asynchronously, released through a short flop chain
  logic [RST_SYNC-1:0] rst_chain;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_chain[RST_SYNC-1];

  // datapath
  nzcv_t             flg_cur, flg_calc;
  logic              cond_ok, is_cmp;
  logic [DATA_W-1:0] alu_res;

  assign flg_cur = nzcv_t'(flags_in);

  pred_cond_eval u_cond (
    .cond (cond_e'(cond)),
    .flg  (flg_cur),
    .pass (cond_ok)
  );

  pred_alu_datapath #(.W(DATA_W)) u_dp (
    .a        (op_a),
    .b        (op_b),
    .shc      (shift_carry),
    .op       (alu_op_e'(opcode)),
    .flg_in   (flg_cur),
    .result   (alu_res),
    .flg_calc (flg_calc),
    .is_cmp   (is_cmp)
  );

  // next state
  logic              valid_d, we_d;
  logic [DATA_W-1:0] data_d;
  logic [3:0]        flags_d;
  logic              upd_en;

  always_comb begin
    valid_d = op_valid;
    upd_en  = op_valid;
    we_d    = cond_ok && !is_cmp;
    data_d  = alu_res;
    flags_d = (cond_ok && (set_flags || is_cmp)) ? flg_calc : flg_cur;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_data  <= '0;
      nxt_flags <= '0;
    end else begin
      res_valid <= valid_d;
      if (upd_en) begin
        res_we    <= we_d;
        res_data  <= data_d;
        nxt_flags <= flags_d;
      end
    end
  end

endmodule

// File: rtl/pred_alu_stage_chk.sv
module pred_alu_stage_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        opcode,
  input logic [3:0]        cond,
  input logic              set_flags,
  input logic [3:0]        flags_in,
  input logic              res_valid,
  input logic              res_we,
  input logic [DATA_W-1:0] res_data,
  input logic [3:0]        nxt_flags
);

  logic cmp_op, logic_op;
  assign cmp_op   = (opcode[3:2] == 2'b10);
  assign logic_op = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd8) ||
                    (opcode == 4'd9) || (opcode >= 4'd12);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cmp_op |=> !res_we); // R3

  AST_FLAGS_HELD_NO_S: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !cmp_op && !set_flags |=> nxt_flags == $past(flags_in)); // R4

  AST_NEVER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cond == 4'hF |=> !res_we && nxt_flags == $past(flags_in)); // R6

  AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cond == 4'hE && !cmp_op |=> res_we); // R5

  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && logic_op && cond == 4'hE |=> nxt_flags[0] == $past(flags_in[0])); // R8

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cond == 4'hE && set_flags && !cmp_op |=>
      nxt_flags[3] == res_data[DATA_W-1] && nxt_flags[2] == (res_data == '0)); // R9

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid)); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data) && $stable(nxt_flags) && $stable(res_we)); // R10

endmodule

bind pred_alu_stage pred_alu_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .cond      (cond),
  .set_flags (set_flags),
  .flags_in  (flags_in),
  .res_valid (res_valid),
  .res_we    (res_we),
  .res_data  (res_data),
  .nxt_flags (nxt_flags)
);

// File: tb/tb_pred_alu_stage.sv
module tb_pred_alu_stage;

  localparam logic [3:0] AND_ = 4'h0, EOR_ = 4'h1, SUB_ = 4'h2, RSB_ = 4'h3,
                         ADD_ = 4'h4, ADC_ = 4'h5, SBC_ = 4'h6, RSC_ = 4'h7,
                         TST_ = 4'h8, TEQ_ = 4'h9, CMP_ = 4'hA, CMN_ = 4'hB,
                         ORR_ = 4'hC, MOV_ = 4'hD, BIC_ = 4'hE, MVN_ = 4'hF;
  localparam logic [3:0] EQ_ = 4'd0, AL_ = 4'd14, NV_ = 4'd15;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  cc;
    logic        s;
    logic [3:0]  fl;
    logic        shc;
    logic [31:0] a;
    logic [31:0] b;
    logic        we;
    logic [31:0] res;
    logic [3:0]  efl;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{ADD_, AL_, 1'b1, 4'b0000, 1'b0, 32'h1,        32'h2,        1'b1, 32'h3,        4'b0000}, // R1
    '{ADD_, AL_, 1'b1, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'h1,        1'b1, 32'h0,        4'b0110}, // R7
    '{ADD_, AL_, 1'b1, 4'b0000, 1'b0, 32'h7FFFFFFF, 32'h1,        1'b1, 32'h80000000, 4'b1001}, // R7
    '{SUB_, AL_, 1'b1, 4'b0000, 1'b0, 32'h5,        32'h5,        1'b1, 32'h0,        4'b0110}, // R7
    '{SUB_, AL_, 1'b1, 4'b0000, 1'b0, 32'h3,        32'h5,        1'b1, 32'hFFFFFFFE, 4'b1000}, // R7
    '{RSB_, AL_, 1'b1, 4'b0000, 1'b0, 32'h3,        32'h5,        1'b1, 32'h2,        4'b0010}, // R1
    '{ADC_, AL_, 1'b1, 4'b0010, 1'b0, 32'h1,        32'h1,        1'b1, 32'h3,        4'b0000}, // R1
    '{SBC_, AL_, 1'b1, 4'b0000, 1'b0, 32'h5,        32'h2,        1'b1, 32'h2,        4'b0010}, // R1
    '{RSC_, AL_, 1'b1, 4'b0010, 1'b0, 32'h2,        32'h7,        1'b1, 32'h5,        4'b0010}, // R1
    '{CMP_, AL_, 1'b0, 4'b0000, 1'b0, 32'h4,        32'h4,        1'b0, 32'h0,        4'b0110}, // R3
    '{TST_, AL_, 1'b0, 4'b0001, 1'b1, 32'hF0,       32'h0F,       1'b0, 32'h0,        4'b0111}, // R3
    '{TEQ_, AL_, 1'b0, 4'b0000, 1'b0, 32'h80000000, 32'h0,        1'b0, 32'h0,        4'b1000}, // R3
    '{CMN_, AL_, 1'b0, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'h1,        1'b0, 32'h0,        4'b0110}, // R3
    '{AND_, AL_, 1'b1, 4'b0001, 1'b1, 32'hFF00,     32'h0FF0,     1'b1, 32'h0F00,     4'b0011}, // R8
    '{EOR_, AL_, 1'b0, 4'b1010, 1'b0, 32'hFF,       32'h0F,       1'b1, 32'hF0,       4'b1010}, // R4
    '{ORR_, AL_, 1'b1, 4'b0000, 1'b0, 32'h0,        32'h0,        1'b1, 32'h0,        4'b0100}, // R9
    '{BIC_, AL_, 1'b1, 4'b0000, 1'b0, 32'hFF,       32'h0F,       1'b1, 32'hF0,       4'b0000}, // R2
    '{MOV_, AL_, 1'b1, 4'b0000, 1'b0, 32'h12345678, 32'h80000000, 1'b1, 32'h80000000, 4'b1000}, // R2
    '{MVN_, AL_, 1'b1, 4'b0000, 1'b1, 32'hDEAD,     32'h0,        1'b1, 32'hFFFFFFFF, 4'b1010}, // R2
    '{ADD_, EQ_, 1'b1, 4'b0000, 1'b0, 32'h1,        32'h1,        1'b0, 32'h0,        4'b0000}, // R6
    '{ADD_, EQ_, 1'b0, 4'b0100, 1'b0, 32'h1,        32'h1,        1'b1, 32'h2,        4'b0100}, // R5
    '{CMP_, NV_, 1'b0, 4'b0000, 1'b0, 32'h1,        32'h2,        1'b0, 32'h0,        4'b0000}, // R6
    '{SUB_, AL_, 1'b0, 4'b1111, 1'b0, 32'h3,        32'h1,        1'b1, 32'h2,        4'b1111}  // R4
  };

  logic        clk, rst_n, op_valid, shift_carry, set_flags;
  logic [31:0] op_a, op_b, res_data;
  logic [3:0]  opcode, cond, flags_in, nxt_flags;
  logic        res_valid, res_we;
  int checks = 0, fails = 0;

  pred_alu_stage dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .shift_carry(shift_carry), .opcode(opcode), .cond(cond), .set_flags(set_flags),
    .flags_in(flags_in), .res_valid(res_valid), .res_we(res_we),
    .res_data(res_data), .nxt_flags(nxt_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  function automatic logic ref_cond(logic [3:0] cc, logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;            4'd1: return !z;
      4'd2: return c;            4'd3: return !c;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return c & !z;       4'd9: return !c | z;
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z & (n == v);
      4'd13: return z | (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // returns {we, result, flags}
  function automatic logic [36:0] ref_model(logic [3:0] op, logic [3:0] cc, logic s,
                                            logic [3:0] f, logic shc, logic [31:0] a,
                                            logic [31:0] b);
    longint sa, sb, sr, ur;
    logic [31:0] r;
    logic arith, cmp, cf, vf, ci;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ci = f[1]; arith = 1'b1; cf = 1'b0;
    case (op)
      ADD_, CMN_: begin sr = sa + sb;       ur = longint'(a) + longint'(b); end
      ADC_:       begin sr = sa + sb + ci;  ur = longint'(a) + longint'(b) + ci; end
      SUB_, CMP_: begin sr = sa - sb;       ur = longint'(a) - longint'(b); end
      SBC_:       begin sr = sa - sb - !ci; ur = longint'(a) - longint'(b) - !ci; end
      RSB_:       begin sr = sb - sa;       ur = longint'(b) - longint'(a); end
      RSC_:       begin sr = sb - sa - !ci; ur = longint'(b) - longint'(a) - !ci; end
      default:    begin sr = 0; ur = 0; arith = 1'b0; end
    endcase
    case (op)
      AND_, TST_: r = a & b;
      EOR_, TEQ_: r = a ^ b;
      ORR_: r = a | b;
      BIC_: r = a & ~b;
      MOV_: r = b;
      MVN_: r = ~b;
      default: r = ur[31:0];
    endcase
    if (arith) begin
      if (op == ADD_ || op == ADC_ || op == CMN_) cf = (ur > 64'sh0FFFFFFFF);
      else cf = (ur >= 0);
      vf = (sr > 64'sh7FFFFFFF) || (sr < -64'sh80000000);
    end else begin
      cf = shc; vf = f[0];
    end
    cmp = (op[3:2] == 2'b10);
    if (!ref_cond(cc, f)) return {1'b0, r, f};
    return {!cmp, r, (s || cmp) ? {r[31], r == 32'h0, cf, vf} : f};
  endfunction

  task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [3:0] cc, logic s, logic [3:0] f,
                       logic shc, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; cond = cc; set_flags = s; flags_in = f;
    shift_carry = shc; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [36:0] e;
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; cond = '0; set_flags = 1'b0;
    flags_in = '0; shift_carry = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset outputs", {res_valid, res_we, res_data, nxt_flags[1:0]}, 36'h0);
    check("R10", "reset flags", {32'h0, nxt_flags}, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].cc, VECS[i].s, VECS[i].fl, VECS[i].shc, VECS[i].a, VECS[i].b);
      check("R1-table R3", $sformatf("vec %0d we", i), {35'h0, res_we}, {35'h0, VECS[i].we});
      if (VECS[i].we)
        check("R1", $sformatf("vec %0d result", i), {4'h0, res_data}, {4'h0, VECS[i].res});
      check("R7 R9", $sformatf("vec %0d flags", i), {32'h0, nxt_flags}, {32'h0, VECS[i].efl});
      check("R10", $sformatf("vec %0d valid", i), {35'h0, res_valid}, 36'h1);
    end

    // R5 all condition codes against all flag values (MOV, S=0)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(MOV_, 4'(c), 1'b0, 4'(f), 1'b0, 32'h0, 32'h55);
        check("R5", $sformatf("cond %0d flags %0h we", c, f), {35'h0, res_we},
              {35'h0, ref_cond(4'(c), 4'(f))});
        check("R6", "flags untouched", {32'h0, nxt_flags}, {32'h0, 4'(f)});
      end
    end

    // R2 MOV ignores operand A
    apply(MOV_, AL_, 1'b1, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'h1234);
    check("R2", "MOV a=ones result", {4'h0, res_data}, {4'h0, 32'h1234});
    apply(MOV_, AL_, 1'b1, 4'b0000, 1'b0, 32'h0, 32'h1234);
    check("R2", "MOV a=zero result", {4'h0, res_data}, {4'h0, 32'h1234});

    // R10 hold while idle
    apply(ADD_, AL_, 1'b1, 4'b0000, 1'b0, 32'h10, 32'h20);
    op_a = 32'hAAAA; op_b = 32'h5555; opcode = SUB_; flags_in = 4'hF;
    repeat (3) @(negedge clk);
    check("R10", "hold data", {4'h0, res_data}, {4'h0, 32'h30});
    check("R10", "idle valid low", {35'h0, res_valid}, 36'h0);

    // random operations against the model
    for (int k = 0; k < 600; k++) begin
      logic [3:0] op, cc, f;
      logic s, shc;
      logic [31:0] a, b;
      op = 4'($urandom); cc = 4'($urandom % 15); f = 4'($urandom);
      s = 1'($urandom); shc = 1'($urandom);
      a = (k % 4 == 0) ? 32'h7FFFFFFF + 32'($urandom % 3) : $urandom;
      b = (k % 5 == 0) ? 32'($urandom % 3) : $urandom;
      e = ref_model(op, cc, s, f, shc, a, b);
      apply(op, cc, s, f, shc, a, b);
      check("R1 R2 R3", $sformatf("rand %0d we", k), {35'h0, res_we}, {35'h0, e[36]});
      if (e[36]) check("R1 R2", $sformatf("rand %0d result", k), {4'h0, res_data}, {4'h0, e[35:4]});
      check("R4 R7 R8 R9", $sformatf("rand %0d flags", k), {32'h0, nxt_flags}, {32'h0, e[3:0]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule